// File: doc/BRIEF.md
# Battery Temperature Zone Controller

This block sorts the battery pack temperature into zones, using voltage samples taken from a thermistor divider, and derives the charger adjustments that belong to each zone. A higher thermistor voltage means a colder pack. Every comparison is therefore inverted: the cold side is above a threshold and the hot side is below one. Five 8-bit thresholds (open, cold, cool, warm, hot) are compared with the upper byte of a 16-bit sample, which spans a 1.2 V full scale. For a 10 k NTC pack the typical codes are 192 (open), 124 (cold), 109 (cool), 56 (warm) and 39 (hot).

The zone register updates only when a sample arrives with its valid strobe. A registered effect stage then works out, from the zone, the control mode, the fast-charge current code and the cool-region fraction:

- the charge enable;
- the current code, in steps of 1.25 mA;
- the reduced regulation voltage select;
- the timer suspend;
- the termination inhibit.

Each change of zone produces a one-cycle interrupt request and sets a sticky flag for the zone that was entered. The flags stay set until a read strobe clears them.

Top module: `tzone_ctrl`

## Requirements
- R1: After reset the zone is normal (code 0), and irq_o, flags_o, vred_o, term_inh_o and tmr_susp_o are 0. From the second cycle after reset, chg_en_o is 1 and icur_o equals ichg_i.
- R2: Only bits [15:8] of smp_i are classified. zone_o changes only on the cycle after a clock edge at which smp_vld_i is 1. A sample presented without the strobe has no effect.
- R3: Zone codes are normal 0, cool 1, warm 2, cold 3, hot 4 and open 5. Let v be smp_i[15:8]. The zone is chosen in this priority order:
  - open when v > thr_open_i;
  - else cold when v > thr_cold_i;
  - else hot when v < thr_hot_i;
  - else cool when v > thr_cool_i;
  - else warm when v < thr_warm_i;
  - else normal.
  A value equal to a threshold therefore falls in the less extreme zone. The zone is classified and reported the same way in every mode.
- R4: In an effective open, cold or hot zone: chg_en_o is 0, icur_o is 0 and tmr_susp_o is 1.
- R5: In an effective cool zone, icur_o = floor(ichg_i × N / 8). N is 1, 2, 4 or 6 for cool_sel_i = 0, 1, 2 or 3. Charging stays enabled.
- R6: In an effective warm zone, vred_o and term_inh_o are 1, chg_en_o is 1 and icur_o equals ichg_i. In every other effective zone, vred_o and term_inh_o are 0.
- R7: mode_i = 0 is four-region control. mode_i = 1 is hot/cold-only control, in which the cool and warm zones take the normal-zone effects.
- R8: mode_i = 2 or 3 disables temperature control. Every zone then takes the normal-zone effects: chg_en_o 1, icur_o = ichg_i, and vred_o, term_inh_o and tmr_susp_o all 0.
- R9: A strobed sample whose zone differs from the current zone makes irq_o 1 for exactly the next cycle. It also sets flags_o bit [new zone code]. This happens in every mode. A strobed sample in the same zone raises no request.
- R10: flags_o bits stay set until flag_rd_i is 1, which clears all bits on the next cycle. A flag being set in that same cycle stays set.
- R11: zone_o and irq_o register one edge after the strobe. The effect outputs (chg_en_o, icur_o, vred_o, term_inh_o, tmr_susp_o) register one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | 16 | Thermistor voltage sample |
| thr_open_i | input | 8 | Open-pack threshold |
| thr_cold_i | input | 8 | Cold threshold |
| thr_cool_i | input | 8 | Cool threshold |
| thr_warm_i | input | 8 | Warm threshold |
| thr_hot_i | input | 8 | Hot threshold |
| mode_i | input | 2 | 0 four-region, 1 hot/cold-only, 2/3 disabled |
| ichg_i | input | 10 | Fast-charge current code (1.25 mA steps) |
| cool_sel_i | input | 2 | Cool-region fraction select |
| flag_rd_i | input | 1 | Flag read strobe, clears flags |
| zone_o | output | 3 | Current zone code |
| chg_en_o | output | 1 | Charge enable |
| icur_o | output | 10 | Charge current code to apply |
| vred_o | output | 1 | Reduced regulation voltage select |
| term_inh_o | output | 1 | Charge termination inhibit |
| tmr_susp_o | output | 1 | Charge and safety timer suspend |
| irq_o | output | 1 | One-cycle interrupt request |
| flags_o | output | 6 | Sticky zone-entry flags, bit index = zone code |

## Verification
A strobed sample that changes the zone can arrive in the same cycle as the flag read strobe. The setting of the new zone's flag then competes with the clearing of all flags. The bench provokes this by building up earlier flags, then driving a sample for a different zone together with flag_rd_i for one cycle. It expects exactly the new zone's bit to remain, and the interrupt request to still fire. A second collision lies in the timing: the zone and the interrupt change one edge before the effect outputs. The bench checks the old charge enable and the new zone together, and then the new charge enable one cycle later.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int ZONE_W = 3;
  localparam int NZONE  = 6;
  localparam int FRAC_SH = 3;

  typedef enum logic [ZONE_W-1:0] {
    ZN_NORMAL = 3'd0,
    ZN_COOL   = 3'd1,
    ZN_WARM   = 3'd2,
    ZN_COLD   = 3'd3,
    ZN_HOT    = 3'd4,
    ZN_OPEN   = 3'd5
  } zone_e;

  // numerator over 2**FRAC_SH for the cool-region fraction
  function automatic logic [FRAC_SH-1:0] frac_num(input logic [1:0] sel);
    case (sel)
      2'd0:    frac_num = 3'd1;
      2'd1:    frac_num = 3'd2;
      2'd2:    frac_num = 3'd4;
      default: frac_num = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/tz_classify.sv
module tz_classify
  import tz_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [THR_W-1:0] thr_open_i,
  input  logic [THR_W-1:0] thr_cold_i,
  input  logic [THR_W-1:0] thr_cool_i,
  input  logic [THR_W-1:0] thr_warm_i,
  input  logic [THR_W-1:0] thr_hot_i,
  output zone_e            zone_nxt_o,
  output zone_e            zone_q_o
);
  localparam int LO_W = SMP_W - THR_W;

  logic [THR_W-1:0] lvl;
  logic             unused_lo;
  zone_e            zone_q;

  assign lvl       = smp_i[SMP_W-1 -: THR_W];
  assign unused_lo = ^smp_i[LO_W-1:0];

  // higher voltage = colder pack; equality falls to the milder zone
  always_comb begin
    if (lvl > thr_open_i)      zone_nxt_o = ZN_OPEN;
    else if (lvl > thr_cold_i) zone_nxt_o = ZN_COLD;
    else if (lvl < thr_hot_i)  zone_nxt_o = ZN_HOT;
    else if (lvl > thr_cool_i) zone_nxt_o = ZN_COOL;
    else if (lvl < thr_warm_i) zone_nxt_o = ZN_WARM;
    else                       zone_nxt_o = ZN_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst)            zone_q <= ZN_NORMAL;
    else if (smp_vld_i) zone_q <= zone_nxt_o;
  end

  assign zone_q_o = zone_q;

  assert_zone_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !smp_vld_i |=> $stable(zone_q));

  assert_open_first_R3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && (smp_i[SMP_W-1 -: THR_W] > thr_open_i)) |=> (zone_q == ZN_OPEN));
endmodule

// File: rtl/tz_effects.sv
module tz_effects
  import tz_pkg::*;
#(
  parameter int CUR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  zone_e            zone_i,
  input  logic [1:0]       mode_i,
  input  logic [CUR_W-1:0] ichg_i,
  input  logic [1:0]       cool_sel_i,
  output logic             chg_en_o,
  output logic [CUR_W-1:0] icur_o,
  output logic             vred_o,
  output logic             term_inh_o,
  output logic             tmr_susp_o
);
  localparam int PW = CUR_W + FRAC_SH;

  zone_e            eff;
  logic [PW-1:0]    prod;
  logic [CUR_W-1:0] cool_cur;
  logic             stop;
  logic [CUR_W-1:0] cur_nxt;
  logic             live_q;

  always_comb begin
    eff = zone_i;
    if (mode_i[1]) eff = ZN_NORMAL;
    else if (mode_i[0] && (zone_i == ZN_COOL || zone_i == ZN_WARM)) eff = ZN_NORMAL;
  end

  assign prod     = PW'(ichg_i) * PW'(frac_num(cool_sel_i));
  assign cool_cur = prod[PW-1:FRAC_SH];
  assign stop     = (eff == ZN_OPEN) || (eff == ZN_COLD) || (eff == ZN_HOT);

  always_comb begin
    if (stop)                cur_nxt = '0;
    else if (eff == ZN_COOL) cur_nxt = cool_cur;
    else                     cur_nxt = ichg_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en_o   <= 1'b1;
      icur_o     <= '0;
      vred_o     <= 1'b0;
      term_inh_o <= 1'b0;
      tmr_susp_o <= 1'b0;
      live_q     <= 1'b0;
    end else begin
      chg_en_o   <= !stop;
      icur_o     <= cur_nxt;
      vred_o     <= (eff == ZN_WARM);
      term_inh_o <= (eff == ZN_WARM);
      tmr_susp_o <= stop;
      live_q     <= 1'b1;
    end
  end

  assert_stop_no_current_R4: assert property (@(posedge clk) disable iff (rst)
    !chg_en_o |-> (icur_o == '0) && tmr_susp_o);

  assert_cur_bound_R5: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (icur_o <= $past(ichg_i)));

  assert_warm_pair_R6: assert property (@(posedge clk) disable iff (rst)
    vred_o |-> term_inh_o && chg_en_o);

  assert_off_mode_R8: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode_i[1])) |-> chg_en_o && !vred_o && (icur_o == $past(ichg_i)));
endmodule

// File: rtl/tz_events.sv
module tz_events
  import tz_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld_i,
  input  zone_e            zone_nxt_i,
  input  zone_e            zone_q_i,
  input  logic             flag_rd_i,
  output logic             irq_o,
  output logic [NZONE-1:0] flags_o
);
  logic change;

  assign change = smp_vld_i && (zone_nxt_i != zone_q_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= change;
  end

  for (genvar z = 0; z < NZONE; z++) begin : g_flag
    logic hit;
    assign hit = change && (zone_nxt_i == zone_e'(z));
    always_ff @(posedge clk) begin
      if (rst)            flags_o[z] <= 1'b0;
      else if (hit)       flags_o[z] <= 1'b1;
      else if (flag_rd_i) flags_o[z] <= 1'b0;
    end
  end

  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flags_o[zone_q_i]);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_rd_i && !change) |=> (flags_o == '0));
endmodule

// File: rtl/tzone_ctrl.sv
module tzone_ctrl
  import tz_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int THR_W = 8,
  parameter int CUR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [THR_W-1:0] thr_open_i,
  input  logic [THR_W-1:0] thr_cold_i,
  input  logic [THR_W-1:0] thr_cool_i,
  input  logic [THR_W-1:0] thr_warm_i,
  input  logic [THR_W-1:0] thr_hot_i,
  input  logic [1:0]       mode_i,
  input  logic [CUR_W-1:0] ichg_i,
  input  logic [1:0]       cool_sel_i,
  input  logic             flag_rd_i,
  output logic [2:0]       zone_o,
  output logic             chg_en_o,
  output logic [CUR_W-1:0] icur_o,
  output logic             vred_o,
  output logic             term_inh_o,
  output logic             tmr_susp_o,
  output logic             irq_o,
  output logic [5:0]       flags_o
);
  zone_e zone_nxt;
  zone_e zone_q;

  tz_classify #(.SMP_W(SMP_W), .THR_W(THR_W)) i_classify (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .thr_open_i(thr_open_i), .thr_cold_i(thr_cold_i), .thr_cool_i(thr_cool_i),
    .thr_warm_i(thr_warm_i), .thr_hot_i(thr_hot_i),
    .zone_nxt_o(zone_nxt), .zone_q_o(zone_q)
  );

  tz_effects #(.CUR_W(CUR_W)) i_effects (
    .clk(clk), .rst(rst), .zone_i(zone_q), .mode_i(mode_i), .ichg_i(ichg_i),
    .cool_sel_i(cool_sel_i), .chg_en_o(chg_en_o), .icur_o(icur_o),
    .vred_o(vred_o), .term_inh_o(term_inh_o), .tmr_susp_o(tmr_susp_o)
  );

  tz_events i_events (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .zone_nxt_i(zone_nxt),
    .zone_q_i(zone_q), .flag_rd_i(flag_rd_i), .irq_o(irq_o), .flags_o(flags_o)
  );

  assign zone_o = zone_q;
endmodule

// File: tb/test_tzone_ctrl.sv
module test_tzone_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [15:0] smp = '0;
  logic [1:0] mode = 2'd0;
  logic [9:0] ichg = 10'd80;
  logic [1:0] csel = 2'd0;
  logic frd = 1'b0;
  logic [2:0] zone;
  logic chg_en, vred, term_inh, susp, irq;
  logic [9:0] icur;
  logic [5:0] flags;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tzone_ctrl i_tzone_ctrl (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld), .smp_i(smp),
    .thr_open_i(8'd192), .thr_cold_i(8'd124), .thr_cool_i(8'd109),
    .thr_warm_i(8'd56), .thr_hot_i(8'd39), .mode_i(mode), .ichg_i(ichg),
    .cool_sel_i(csel), .flag_rd_i(frd), .zone_o(zone), .chg_en_o(chg_en),
    .icur_o(icur), .vred_o(vred), .term_inh_o(term_inh), .tmr_susp_o(susp),
    .irq_o(irq), .flags_o(flags)
  );

  // fields: lvl[37:30] mode[29:28] sel[27:26] ichg[25:16] zone[15:13] chg[12] icur[11:2] vred[1] susp[0]
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {8'd200, 2'd0, 2'd0, 10'd80,   3'd5, 1'b0, 10'd0,   1'b0, 1'b1}, // R3 R4 open
    {8'd192, 2'd0, 2'd0, 10'd80,   3'd3, 1'b0, 10'd0,   1'b0, 1'b1}, // R3 equal open -> cold
    {8'd125, 2'd0, 2'd0, 10'd80,   3'd3, 1'b0, 10'd0,   1'b0, 1'b1}, // R4 cold
    {8'd124, 2'd0, 2'd0, 10'd80,   3'd1, 1'b1, 10'd10,  1'b0, 1'b0}, // R3 R5 equal cold -> cool
    {8'd110, 2'd0, 2'd3, 10'd12,   3'd1, 1'b1, 10'd9,   1'b0, 1'b0}, // R5 12*6/8
    {8'd109, 2'd0, 2'd0, 10'd80,   3'd0, 1'b1, 10'd80,  1'b0, 1'b0}, // R3 equal cool -> normal
    {8'd56,  2'd0, 2'd0, 10'd80,   3'd0, 1'b1, 10'd80,  1'b0, 1'b0}, // R3 equal warm -> normal
    {8'd55,  2'd0, 2'd0, 10'd80,   3'd2, 1'b1, 10'd80,  1'b1, 1'b0}, // R6 warm
    {8'd39,  2'd0, 2'd0, 10'd80,   3'd2, 1'b1, 10'd80,  1'b1, 1'b0}, // R3 equal hot -> warm
    {8'd38,  2'd0, 2'd0, 10'd80,   3'd4, 1'b0, 10'd0,   1'b0, 1'b1}, // R4 hot
    {8'd0,   2'd0, 2'd0, 10'd80,   3'd4, 1'b0, 10'd0,   1'b0, 1'b1}, // R4 hot floor
    {8'd115, 2'd1, 2'd0, 10'd80,   3'd1, 1'b1, 10'd80,  1'b0, 1'b0}, // R7 cool as normal
    {8'd50,  2'd1, 2'd0, 10'd80,   3'd2, 1'b1, 10'd80,  1'b0, 1'b0}, // R7 warm as normal
    {8'd130, 2'd1, 2'd0, 10'd80,   3'd3, 1'b0, 10'd0,   1'b0, 1'b1}, // R7 cold still stops
    {8'd200, 2'd2, 2'd0, 10'd80,   3'd5, 1'b1, 10'd80,  1'b0, 1'b0}, // R8 open ignored
    {8'd20,  2'd3, 2'd0, 10'd80,   3'd4, 1'b1, 10'd80,  1'b0, 1'b0}, // R8 hot ignored
    {8'd120, 2'd0, 2'd2, 10'd13,   3'd1, 1'b1, 10'd6,   1'b0, 1'b0}, // R5 13*4/8 floor
    {8'd118, 2'd0, 2'd1, 10'd3,    3'd1, 1'b1, 10'd0,   1'b0, 1'b0}, // R5 3*2/8 floor
    {8'd121, 2'd0, 2'd0, 10'd1023, 3'd1, 1'b1, 10'd127, 1'b0, 1'b0}  // R5 max code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] lvl, input logic rd);
    @(negedge clk);
    smp = {lvl, 8'hA5};
    smp_vld = 1'b1;
    frd = rd;
    @(negedge clk);
    smp_vld = 1'b0;
    frd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 zone", 32'(zone), 32'd0);
    chk("R1 outputs", {chg_en, icur, vred, term_inh, susp, irq}, {1'b1, 10'd80, 4'b0000});
    chk("R1 flags", 32'(flags), 32'd0);

    // R2: sample without strobe
    @(negedge clk) smp = {8'd200, 8'h00};
    repeat (3) @(negedge clk);
    chk("R2 no strobe zone", 32'(zone), 32'd0);
    chk("R2 no strobe chg", 32'(chg_en), 32'd1);

    // R11 and R9: normal -> hot
    strobe(8'd20, 1'b0);
    chk("R11 zone first edge", 32'(zone), 32'd4);
    chk("R9 irq pulse", 32'(irq), 32'd1);
    chk("R11 chg old", 32'(chg_en), 32'd1);
    @(negedge clk);
    chk("R11 chg new", 32'(chg_en), 32'd0);
    chk("R9 irq one cycle", 32'(irq), 32'd0);
    chk("R9 flag hot", 32'(flags), 32'b010000);

    strobe(8'd10, 1'b0);
    chk("R9 same zone no irq", 32'(irq), 32'd0);

    // R10 read clear
    @(negedge clk) frd = 1'b1;
    @(negedge clk) frd = 1'b0;
    chk("R10 read clears", 32'(flags), 32'd0);

    strobe(8'd55, 1'b0);
    chk("R10 flag warm", 32'(flags), 32'b000100);
    strobe(8'd80, 1'b1);
    chk("R10 set wins over read", 32'(flags), 32'b000001);
    chk("R9 irq with read", 32'(irq), 32'd1);
    strobe(8'd150, 1'b0);
    chk("R10 sticky accumulate", 32'(flags), 32'b001001);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      @(negedge clk);
      mode = v[29:28];
      csel = v[27:26];
      ichg = v[25:16];
      strobe(v[37:30], 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i),
          {zone, chg_en, icur, vred, susp, term_inh},
          {v[15:13], v[12], v[11:2], v[1], v[0], v[1]});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule